// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block models a synchronous static memory whose bus never needs an idle cycle when it changes between reads and writes. On each enabled rising clock edge the block captures the address, the three chip selects, the read/write select, the per-lane write masks and the step/load control. A load edge either opens a new access at the given address or puts the device in the deselected state. A step edge moves a two-bit burst counter forward and keeps the direction of the access in progress.

Reads are flow-through. The word that an edge addresses is shown at `rdata` in the cycle after that edge, straight from the array. Writes are split across two edges. The address and lane masks are captured on one edge, and the data on `wdata` is taken and merged on the next enabled edge. A high clock-enable freezes all state. The output enable acts on the drive flag without waiting for a clock edge.

The data pins are plain signals with no valid/ready handshake. Back-pressure is not possible on this memory bus. The only way to pause it is the clock-enable, and a stall keeps the previous cycle in place, including a write that is still waiting for its data.

Top module: `zt_sram`

## Requirements
- R1: On an enabled edge with `step_nload`=0 and all chip selects active (`ce_a_n`=0, `ce_b_n`=0, `ce_c`=1), a new access opens at `addr`. `wr_n`=0 makes it a write and `wr_n`=1 makes it a read.
- R2: On a load edge where any chip select is inactive, the device is deselected. It then drives no data (`rdata_drive`=0) and writes nothing.
- R3: The chip selects are sampled only on load edges. A step edge that follows a deselect keeps the device deselected, whatever the chip selects and `wr_n` are.
- R4: On a step edge of an open access, the low two address bits count up by one and wrap from 3 to 0. The upper bits stay unchanged, `wr_n` is ignored and the direction is kept.
- R5: In the cycle after an edge that registered a read, `rdata` holds the array word at the registered address.
- R6: `bw_n` is captured with the address. `bw_n[i]`=0 lets bits [8i+7:8i] of `wdata` be written on the next enabled edge. Lanes whose bit is 1 keep their old contents.
- R7: While `cen_n`=1, clock edges are ignored. The access state, the output and any waiting write hold unchanged. A waiting write completes with the `wdata` present at the next enabled edge.
- R8: `rdata_drive` is 1 exactly when a read access is open and `oe_n`=0. It follows `oe_n` at once, without waiting for a clock edge.
- R9: After reset the device is deselected and drives nothing.
- R10: A read of an address in the edge right after its write edge returns the newly written data, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Active-low clock enable |
| step_nload | input | 1 | 1: step the burst counter; 0: load a new address |
| wr_n | input | 1 | Active-low write select, used on load edges only |
| ce_a_n | input | 1 | Active-low chip select |
| ce_b_n | input | 1 | Active-low chip select |
| ce_c | input | 1 | Active-high chip select |
| addr | input | ADDR_W | Word address; low two bits seed the burst counter |
| bw_n | input | LANES | Active-low byte-lane write masks, one per 8-bit lane |
| wdata | input | LANES*8 | Write data, taken one enabled edge after its address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | LANES*8 | Flow-through read data |
| rdata_drive | output | 1 | High when `rdata` would be driven onto the bus |

## Verification
A wrong access state shows at the ports within one cycle. A bad burst count or a bad stored row gives the wrong word on the very next read cycle. A lost direction or a deselect that is not kept shows on `rdata_drive` in the next cycle. A write that goes wrong shows up on the first later read of that address. Reading each written location back soon after its burst is therefore what exposes it. Stall and output-enable faults show within the same cycle, because the output must either hold or follow `oe_n` without delay.

// File: rtl/zt_pkg.sv
package zt_pkg;
  localparam int LANE_W = 8;
  localparam int CNT_W  = 2;

  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } dir_e;

  typedef struct packed {
    logic open;
    dir_e dir;
  } acc_state_t;
endpackage

// File: rtl/zt_access_reg.sv
module zt_access_reg
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              step_nload,
  input  logic              wr_n,
  input  logic              ce_a_n,
  input  logic              ce_b_n,
  input  logic              ce_c,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bw_n,
  output acc_state_t        st,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LANES-1:0]  cur_bw_n
);
  localparam int ROW_W = ADDR_W - CNT_W;

  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] cnt_q;
  acc_state_t       st_q;
  logic [LANES-1:0] bw_q;
  logic             sel_all;

  assign sel_all = !ce_a_n && !ce_b_n && ce_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '{open: 1'b0, dir: DIR_READ};
      row_q <= '0;
      cnt_q <= '0;
      bw_q  <= '1;
    end else if (!cen_n) begin
      bw_q <= bw_n;
      if (!step_nload) begin
        st_q.open <= sel_all;
        st_q.dir  <= wr_n ? DIR_READ : DIR_WRITE;
        row_q     <= addr[ADDR_W-1:CNT_W];
        cnt_q     <= addr[CNT_W-1:0];
      end else if (st_q.open) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign st       = st_q;
  assign cur_addr = {row_q, cnt_q};
  assign cur_bw_n = bw_q;

  // R7: a stalled edge leaves the access state untouched
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> ($stable(st_q) && $stable(cnt_q) && $stable(row_q) && $stable(bw_q)));

  // R4: stepping keeps direction and row, and the counter moves by one
  a_r4_step_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && step_nload && st_q.open) |=>
      (st_q.dir == $past(st_q.dir) && row_q == $past(row_q)
       && cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R3: a step after a deselect stays deselected
  a_r3_desel_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && step_nload && !st_q.open) |=> !st_q.open);

  // R2: an inactive chip select on a load closes the device
  a_r2_load_desel: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !step_nload && (ce_a_n || ce_b_n || !ce_c)) |=> !st_q.open);
endmodule

// File: rtl/zt_lane_mem.sv
module zt_lane_mem
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANE_W-1:0] wbyte,
  input  logic [ADDR_W-1:0] raddr,
  output logic [LANE_W-1:0] rbyte
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wbyte;
  end

  assign rbyte = cells[raddr];
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cen_n,
  input  logic                    step_nload,
  input  logic                    wr_n,
  input  logic                    ce_a_n,
  input  logic                    ce_b_n,
  input  logic                    ce_c,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        bw_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_drive
);
  acc_state_t        st;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  cur_bw_n;
  logic              wr_fire;
  logic [LANES-1:0]  lane_we;

  zt_access_reg #(.ADDR_W(ADDR_W), .LANES(LANES)) u_acc (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .step_nload(step_nload),
    .wr_n(wr_n), .ce_a_n(ce_a_n), .ce_b_n(ce_b_n), .ce_c(ce_c),
    .addr(addr), .bw_n(bw_n), .st(st), .cur_addr(cur_addr),
    .cur_bw_n(cur_bw_n)
  );

  // the write registered on the previous edge completes on this enabled edge
  assign wr_fire = !cen_n && st.open && (st.dir == DIR_WRITE);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_we[l] = wr_fire && !cur_bw_n[l];
    zt_lane_mem #(.ADDR_W(ADDR_W)) u_mem (
      .clk(clk), .we(lane_we[l]), .waddr(cur_addr),
      .wbyte(wdata[l*LANE_W +: LANE_W]), .raddr(cur_addr),
      .rbyte(rdata[l*LANE_W +: LANE_W])
    );
  end

  assign rdata_drive = st.open && (st.dir == DIR_READ) && !oe_n;

  // R8: the drive flag and any lane write never overlap
  a_r8_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_drive |-> (lane_we == '0));

  // R9: nothing is driven while in reset
  always_comb begin
    if (!rst_n) a_r9_reset_quiet: assert (!rdata_drive);
  end
endmodule

// File: tb/sim_zt_sram.sv
module sim_zt_sram;
  localparam int AW = 8;
  localparam int LN = 4;
  localparam int DW = LN * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cen_n = 1'b0, step_nload = 1'b0, wr_n = 1'b1;
  logic ce_a_n = 1'b1, ce_b_n = 1'b0, ce_c = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [LN-1:0] bw_n = '1;
  logic [DW-1:0] wdata = '0;
  logic oe_n = 1'b0;
  logic [DW-1:0] rdata;
  logic rdata_drive;

  int checks = 0;
  int errors = 0;

  // behavioural reference
  logic [DW-1:0] ref_mem [int];
  bit            m_open;
  bit            m_read;
  int            m_addr;
  logic [LN-1:0] m_bw;

  always #10 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .LANES(LN)) u0 (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .step_nload(step_nload),
    .wr_n(wr_n), .ce_a_n(ce_a_n), .ce_b_n(ce_b_n), .ce_c(ce_c),
    .addr(addr), .bw_n(bw_n), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .rdata_drive(rdata_drive)
  );

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    bit exp_drive;
    exp_drive = m_open && m_read && !oe_n;
    check(tag, DW'(rdata_drive), DW'(exp_drive));
    if (exp_drive && ref_mem.exists(m_addr))
      check(tag, rdata, ref_mem[m_addr]);
  endtask

  task automatic model_edge();
    logic [DW-1:0] w;
    if (cen_n) return;
    if (m_open && !m_read) begin
      w = ref_mem.exists(m_addr) ? ref_mem[m_addr] : '0;
      for (int l = 0; l < LN; l++)
        if (!m_bw[l]) w[l*8 +: 8] = wdata[l*8 +: 8];
      ref_mem[m_addr] = w;
    end
    m_bw = bw_n;
    if (!step_nload) begin
      m_open = !ce_a_n && !ce_b_n && ce_c;
      m_read = wr_n;
      m_addr = int'(addr);
    end else if (m_open) begin
      m_addr = (m_addr & ~3) | ((m_addr + 1) & 3);
    end
  endtask

  task automatic cyc(input string tag, input bit c_n, input bit ld_n,
                     input bit w_n, input logic [2:0] ces,
                     input logic [AW-1:0] a, input logic [LN-1:0] bw,
                     input logic [DW-1:0] d);
    @(negedge clk);
    cen_n = c_n; step_nload = ld_n; wr_n = w_n;
    ce_a_n = ces[2]; ce_b_n = ces[1]; ce_c = ces[0];
    addr = a; bw_n = bw; wdata = d;
    @(posedge clk);
    model_edge();
    #2;
    compare(tag);
  endtask

  localparam logic [2:0] SEL = 3'b001;

  initial begin : watchdog
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_open = 0; m_read = 1; m_addr = 0; m_bw = '1;
    #25;
    check("R9 reset", DW'(rdata_drive), DW'(0));
    @(negedge clk); rst_n = 1'b1;

    // R1/R6: fill 0x10..0x13 with a load at 0x13 and wrapping steps (R4)
    cyc("R1 load write", 0, 0, 0, SEL, 8'h13, 4'h0, '0);
    cyc("R6 write 0x13", 0, 1, 1, 3'b110, 8'h00, 4'h0, 32'hA0A1A2A3);
    cyc("R4 wrap write 0x10", 0, 1, 0, SEL, 8'h00, 4'h0, 32'hB0B1B2B3);
    cyc("R6 write 0x11", 0, 1, 0, SEL, 8'h00, 4'h0, 32'hC0C1C2C3);
    // R10: read of 0x12 loaded while 0x12 data completes
    cyc("R10 load read", 0, 0, 1, SEL, 8'h12, 4'h0, 32'hD0D1D2D3);
    cyc("R5 read 0x13", 0, 1, 0, SEL, 8'h00, 4'h0, '0);
    cyc("R4 read wrap 0x10", 0, 1, 0, 3'b110, 8'h00, 4'h0, '0);
    cyc("R4 read 0x11", 0, 1, 0, SEL, 8'h00, 4'h0, '0);

    // R6: partial lanes on 0x11 (lanes 0 and 2 written)
    cyc("R6 load mask", 0, 0, 0, SEL, 8'h11, 4'b1010, '0);
    cyc("R6 masked data", 0, 0, 1, SEL, 8'h11, 4'hF, 32'h11223344);
    cyc("R6 read masked", 0, 1, 1, SEL, 8'h00, 4'hF, '0);

    // R2/R3: each select inactive on a load, then a step that must not write
    cyc("R2 desel a", 0, 0, 0, 3'b101, 8'h10, 4'h0, '0);
    cyc("R3 step after desel", 0, 1, 0, SEL, 8'h00, 4'h0, 32'hDEADBEEF);
    cyc("R2 desel b", 0, 0, 0, 3'b011, 8'h10, 4'h0, 32'hDEADBEEF);
    cyc("R2 desel c", 0, 0, 0, 3'b000, 8'h10, 4'h0, 32'hDEADBEEF);
    cyc("R3 step desel", 0, 1, 1, SEL, 8'h00, 4'h0, 32'hDEADBEEF);
    cyc("R2 readback 0x10", 0, 0, 1, SEL, 8'h10, 4'hF, 32'hDEADBEEF);
    cyc("R2 readback 0x11", 0, 1, 1, SEL, 8'h00, 4'hF, '0);

    // R7: stall during a waiting write; data taken at next enabled edge
    cyc("R7 load write 0x20", 0, 0, 0, SEL, 8'h20, 4'h0, '0);
    cyc("R7 stall 1", 1, 0, 1, SEL, 8'h33, 4'hF, 32'hBAD0BAD0);
    cyc("R7 stall 2", 1, 1, 1, 3'b110, 8'h44, 4'hF, 32'hBAD1BAD1);
    cyc("R10 write then read", 0, 0, 1, SEL, 8'h20, 4'hF, 32'h5EED5EED);
    cyc("R7 stall in read", 1, 0, 0, SEL, 8'h10, 4'h0, '0);
    cyc("R5 step read 0x21", 0, 1, 0, SEL, 8'h00, 4'hF, '0);

    // R8: output enable acts without a clock edge
    cyc("R8 read 0x20", 0, 0, 1, SEL, 8'h20, 4'hF, '0);
    #3 oe_n = 1'b1; #1;
    check("R8 oe off async", DW'(rdata_drive), DW'(0));
    #3 oe_n = 1'b0; #1;
    check("R8 oe on async", DW'(rdata_drive), DW'(1));
    check("R8 data", rdata, 32'h5EED5EED);
    cyc("R8 write hides drive", 0, 0, 0, SEL, 8'h30, 4'hF, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule